// File: doc/BRIEF.md
# Signed Divide by Run-Time Constant

This block returns the signed 32-bit quotient of a dividend by a divisor that stays fixed for long stretches but is only known at run time. It never divides. Software works out a signed magic multiplier and a right-shift count for the divisor and writes them, together with the divisor's sign, into a configuration register. Each dividend then goes through a two-stage pipeline:

- the upper word of the signed double-width product of multiplier and dividend;
- an add or subtract of the dividend, chosen by sign;
- an arithmetic right shift;
- a round-toward-zero fix-up.

Dividends enter on a valid/ready stream and quotients leave on another. A beat moves on a side only in a cycle where both valid and ready on that side are high. While `out_ready` is low, the held quotient stays put. Back-pressure travels upstream at once: with both stages full and `out_ready` low, `in_ready` drops in that same cycle.

Top module: `magic_sdiv`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `out_valid` is 0 and `in_ready` is 1.
- R2: The block may be loaded with the magic multiplier and shift derived for a divisor d. Here d is not ±1 and |d| is not a power of two. For every 32-bit dividend n, including -2^31, 0, ±1 and 2^31-1, `out_quot` is then n/d truncated toward zero.
- R3: With `out_ready` high, a dividend accepted in cycle c shows `out_valid` high in cycle c+2 and not in cycle c+1. One dividend can be accepted in every cycle.
- R4: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_quot` does not change in the next cycle.
- R5: When both pipeline stages hold data and `out_ready` is 0, `in_ready` is 0 in that same cycle.
- R6: A configuration write (`cfg_we`=1) takes effect for dividends accepted in later cycles. A dividend accepted in the cycle of the write uses the constants held before it. Without `cfg_we`, the constants never change.
- R7: `cfg_neg`=1 marks a negative divisor. If `cfg_neg`=0 and the multiplier is negative, the dividend is added to the high product. If `cfg_neg`=1 and the multiplier is non-negative, the dividend is subtracted. Otherwise the high product is left as it is.
- R8: After the shift, a negative intermediate value has its sign bit added to it. A negative quotient is therefore rounded toward zero, never toward minus infinity.
- R9: Quotients leave in the order their dividends were accepted, with no loss or duplication.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for the constants |
| cfg_mult | input | 32 | Signed magic multiplier |
| cfg_shift | input | 5 | Post-multiply arithmetic shift count |
| cfg_neg | input | 1 | 1 when the divisor is negative |
| in_valid | input | 1 | Dividend valid |
| in_ready | output | 1 | Block can take a dividend |
| in_dividend | input | 32 | Signed dividend |
| out_valid | output | 1 | Quotient valid |
| out_ready | input | 1 | Consumer takes the quotient |
| out_quot | output | 32 | Signed quotient |

## Verification
The assertions assume a synchronous reset held low for at least one edge. They also assume the consumer may lower `out_ready` at any cycle. The quotient checks assume the loaded constants come from the standard derivation for a divisor that is not ±1 or a power of two. The stimulus derives every constant set inside the bench from a fixed list of such divisors, including negative ones and ones whose shift is zero. It mixes random dividends with the extremes of the range, toggles `in_valid` and `out_ready` at random, and rewrites the constants while dividends are still in flight.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;
  // what stage two does with the dividend before shifting
  typedef enum logic [1:0] {
    CORR_NONE = 2'd0,
    CORR_ADD  = 2'd1,
    CORR_SUB  = 2'd2
  } corr_e;
endpackage

// File: rtl/sdiv_cfg_reg.sv
module sdiv_cfg_reg #(
  parameter int DW = 32,
  parameter int SW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [DW-1:0] mult_in,
  input  logic [SW-1:0] shift_in,
  input  logic          neg_in,
  output logic [DW-1:0] mult,
  output logic [SW-1:0] shift,
  output logic          neg
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mult  <= '0;
      shift <= '0;
      neg   <= 1'b0;
    end else if (we) begin
      mult  <= mult_in;
      shift <= shift_in;
      neg   <= neg_in;
    end
  end

  // R6: constants only move on a write
  a_r6_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> ($stable(mult) && $stable(shift) && $stable(neg)));
endmodule

// File: rtl/sdiv_mulhi_stage.sv
module sdiv_mulhi_stage
  import sdiv_pkg::*;
#(
  parameter int DW = 32,
  parameter int SW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          up_ready,
  input  logic [DW-1:0] in_num,
  input  logic [DW-1:0] mult,
  input  logic [SW-1:0] shift,
  input  logic          neg,
  input  logic          down_ready,
  output logic          st_valid,
  output logic [DW-1:0] st_hi,
  output logic [DW-1:0] st_num,
  output logic [SW-1:0] st_shift,
  output corr_e         st_corr
);
  localparam int PW = 2 * DW;

  logic [PW-1:0] prod_w;
  logic [DW-1:0] hi_w;
  corr_e         corr_w;
  logic          load_w;

  assign prod_w = $signed({{DW{in_num[DW-1]}}, in_num}) *
                  $signed({{DW{mult[DW-1]}}, mult});
  assign hi_w   = DW'(prod_w >> DW);

  always_comb begin
    if (!neg && mult[DW-1])      corr_w = CORR_ADD;
    else if (neg && !mult[DW-1]) corr_w = CORR_SUB;
    else                         corr_w = CORR_NONE;
  end

  assign up_ready = !st_valid || down_ready;
  assign load_w   = up_ready && in_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_valid <= 1'b0;
    end else if (up_ready) begin
      st_valid <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (load_w) begin
      st_hi    <= hi_w;
      st_num   <= in_num;
      st_shift <= shift;
      st_corr  <= corr_w;
    end
  end

  // R5: a stalled full stage refuses new data
  a_r5_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && !down_ready) |-> !up_ready);
endmodule

// File: rtl/sdiv_fix_stage.sv
module sdiv_fix_stage
  import sdiv_pkg::*;
#(
  parameter int DW = 32,
  parameter int SW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          up_ready,
  input  logic [DW-1:0] in_hi,
  input  logic [DW-1:0] in_num,
  input  logic [SW-1:0] in_shift,
  input  corr_e         in_corr,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_quot
);
  logic [DW-1:0] sum_w;
  logic [DW-1:0] shifted_w;
  logic [DW-1:0] quot_w;
  logic          load_w;

  always_comb begin
    case (in_corr)
      CORR_ADD: sum_w = in_hi + in_num;
      CORR_SUB: sum_w = in_hi - in_num;
      default:  sum_w = in_hi;
    endcase
  end

  assign shifted_w = $signed(sum_w) >>> in_shift;
  assign quot_w    = shifted_w + {{(DW-1){1'b0}}, shifted_w[DW-1]};

  assign up_ready = !out_valid || out_ready;
  assign load_w   = up_ready && in_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else if (up_ready) begin
      out_valid <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (load_w) out_quot <= quot_w;
  end

  // R4: held result stays put under back-pressure
  a_r4_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_quot)));

  // R8: negative intermediate never yields a positive quotient
  a_r8_neg_round: assert property (@(posedge clk) disable iff (!rst_n)
    (load_w && shifted_w[DW-1]) |=> ($signed(out_quot) <= 0));

  // R8: non-negative intermediate never yields a negative quotient
  a_r8_pos_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (load_w && !shifted_w[DW-1]) |=> !out_quot[DW-1]);
endmodule

// File: rtl/magic_sdiv.sv
module magic_sdiv
  import sdiv_pkg::*;
#(
  parameter int DW = 32,
  parameter int SW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [DW-1:0] cfg_mult,
  input  logic [SW-1:0] cfg_shift,
  input  logic          cfg_neg,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_dividend,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_quot
);
  logic [DW-1:0] k_mult;
  logic [SW-1:0] k_shift;
  logic          k_neg;

  logic          s1_valid;
  logic [DW-1:0] s1_hi;
  logic [DW-1:0] s1_num;
  logic [SW-1:0] s1_shift;
  corr_e         s1_corr;
  logic          s2_ready;

  sdiv_cfg_reg #(.DW(DW), .SW(SW)) i_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we),
    .mult_in(cfg_mult), .shift_in(cfg_shift), .neg_in(cfg_neg),
    .mult(k_mult), .shift(k_shift), .neg(k_neg)
  );

  sdiv_mulhi_stage #(.DW(DW), .SW(SW)) i_s1 (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .up_ready(in_ready), .in_num(in_dividend),
    .mult(k_mult), .shift(k_shift), .neg(k_neg),
    .down_ready(s2_ready),
    .st_valid(s1_valid), .st_hi(s1_hi), .st_num(s1_num),
    .st_shift(s1_shift), .st_corr(s1_corr)
  );

  sdiv_fix_stage #(.DW(DW), .SW(SW)) i_s2 (
    .clk(clk), .rst_n(rst_n),
    .in_valid(s1_valid), .up_ready(s2_ready),
    .in_hi(s1_hi), .in_num(s1_num), .in_shift(s1_shift), .in_corr(s1_corr),
    .out_valid(out_valid), .out_ready(out_ready), .out_quot(out_quot)
  );

  // R3: a first-stage result moves on whenever stage two can take it
  a_r3_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s2_ready) |=> out_valid);

  // R5: both stages full and sink stalled means input blocked
  a_r5_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && out_valid && !out_ready) |-> !in_ready);
endmodule

// File: tb/test_magic_sdiv.sv
module test_magic_sdiv;
  timeunit 1ns;
  timeprecision 100ps;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_mult = '0;
  logic [4:0]  cfg_shift = '0;
  logic        cfg_neg = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_dividend = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_quot;

  always #2.5 clk = ~clk;

  magic_sdiv i_magic_sdiv (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mult(cfg_mult),
    .cfg_shift(cfg_shift), .cfg_neg(cfg_neg), .in_valid(in_valid),
    .in_ready(in_ready), .in_dividend(in_dividend), .out_valid(out_valid),
    .out_ready(out_ready), .out_quot(out_quot)
  );

  int total = 0;
  int bad = 0;
  int    exp_q[$];
  string exp_tag[$];
  int          cur_d = 3;
  logic [31:0] cur_m = '0;
  bit          wr_flag = 0;
  int divs[12] = '{3, -3, 5, 7, -7, 6, -6, 10, -100, 641, -12345, 1000003};

  // standard derivation of signed magic constants for 32-bit words
  function automatic void magic(input int d, output logic [31:0] m, output int s);
    logic [31:0] du, ad, t, anc, q1, r1, q2, r2, delta;
    int p;
    du  = d;
    ad  = (d < 0) ? -du : du;
    t   = 32'h8000_0000 + (du >> 31);
    anc = t - 1 - (t % ad);
    p   = 31;
    q1  = 32'h8000_0000 / anc;
    r1  = 32'h8000_0000 - q1 * anc;
    q2  = 32'h8000_0000 / ad;
    r2  = 32'h8000_0000 - q2 * ad;
    do begin
      p  = p + 1;
      q1 = q1 * 2; r1 = r1 * 2;
      if (r1 >= anc) begin q1 = q1 + 1; r1 = r1 - anc; end
      q2 = q2 * 2; r2 = r2 * 2;
      if (r2 >= ad) begin q2 = q2 + 1; r2 = r2 - ad; end
      delta = ad - r2;
    end while (q1 < delta || (q1 == delta && r1 == 0));
    m = q2 + 1;
    if (d < 0) m = -m;
    s = p - 32;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic report();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  // one cycle: drive after the falling edge, evaluate 1 ns later
  task automatic tick(input bit v, input int n, input bit ro, input bit we,
                      input int dnew, output bit infire);
    logic [31:0] m;
    int s;
    int e;
    string tg;
    @(negedge clk);
    in_valid    = v;
    in_dividend = n;
    out_ready   = ro;
    cfg_we      = we;
    if (we) begin
      magic(dnew, m, s);
      cfg_mult  = m;
      cfg_shift = s[4:0];
      cfg_neg   = (dnew < 0);
    end
    #1;
    infire = in_valid && in_ready;
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        chk(0, "R9 extra quotient", $signed(out_quot), 0);
      end else begin
        e  = exp_q.pop_front();
        tg = exp_tag.pop_front();
        chk($signed(out_quot) == e, tg, $signed(out_quot), e);
      end
    end
    if (infire) begin
      e = n / cur_d;
      if (we) tg = "R6 old constants";
      else if ((cur_d > 0 && cur_m[31]) || (cur_d < 0 && !cur_m[31])) tg = "R7 corrected";
      else if (e < 0) tg = "R8 negative";
      else tg = "R2 quotient";
      exp_q.push_back(e);
      exp_tag.push_back(tg);
    end
    if (we) begin
      cur_d = dnew;
      magic(dnew, cur_m, s);
    end
  endtask

  task automatic send(input int n, input int pct);
    bit f = 0;
    while (!f) tick(1, n, ($urandom_range(99) < pct), 0, 0, f);
  endtask

  task automatic drain();
    bit f;
    for (int i = 0; i < 8; i++) tick(0, 0, 1, 0, 0, f);
    chk(exp_q.size() == 0, "R9 lost quotient", exp_q.size(), 0);
  endtask

  task automatic setd(input int d);
    bit f;
    tick(0, 0, 1, 1, d, f);
  endtask

  initial begin
    #(5.0 * 150000);
    chk(0, "watchdog expired", 0, 1);
    report();
    $finish;
  end

  initial begin
    bit f;
    int hold;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    chk(out_valid == 0, "R1 out_valid in reset", out_valid, 0);
    chk(in_ready == 1, "R1 in_ready in reset", in_ready, 1);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(out_valid == 0, "R1 out_valid after reset", out_valid, 0);
    chk(in_ready == 1, "R1 in_ready after reset", in_ready, 1);

    // R3: latency and per-cycle throughput
    setd(7);
    tick(1, 100, 1, 0, 0, f);
    chk(f, "R3 accept", f, 1);
    tick(1, -100, 1, 0, 0, f);
    chk(f, "R3 back-to-back accept", f, 1);
    chk(out_valid == 0, "R3 not early", out_valid, 0);
    tick(0, 0, 1, 0, 0, f);
    chk(out_valid == 1, "R3 two-cycle result", out_valid, 1);
    drain();

    // R4 / R5: stall with a full pipeline
    setd(-3);
    tick(1, 11, 0, 0, 0, f);
    tick(1, -11, 0, 0, 0, f);
    tick(1, 5, 0, 0, 0, f);
    chk(!f, "R5 input blocked", f, 0);
    chk(out_valid == 1, "R4 valid under stall", out_valid, 1);
    hold = $signed(out_quot);
    tick(1, 5, 0, 0, 0, f);
    chk($signed(out_quot) == hold && out_valid, "R4 held quotient", $signed(out_quot), hold);
    send(5, 100);
    drain();

    // R2 / R7 / R8 per divisor; R6 by rewriting constants mid-stream
    foreach (divs[k]) begin
      setd(divs[k]);
      send(0, 80);
      send(1, 80);
      send(-1, 80);
      send(32'h7fff_ffff, 80);
      send(32'h8000_0000, 80);
      send(divs[k], 80);
      send(-divs[k], 80);
      send(divs[k] - 1, 80);
      send(1 - divs[k], 80);
      for (int i = 0; i < 40; i++) begin
        if ($urandom_range(99) < 20) tick(0, 0, $urandom_range(1), 0, 0, f);
        send(int'($urandom), 70);
      end
      f = 0;
      tick(1, int'($urandom), 1, 1, divs[(k + 1) % 12], f);
      if (!f) send(in_dividend, 100);
      for (int i = 0; i < 10; i++) send(int'($urandom), 70);
      drain();
    end

    report();
    $finish;
  end
endmodule